// File: doc/BRIEF.md
# Electrical Idle Inference Unit

This unit decides that a serial link receiver has gone electrically idle without looking at the analog line. It watches for traffic that the current link-training state says must keep arriving. If that traffic stays absent for a set window, the unit raises an inferred-idle flag. The link training controller supplies a 3-bit selector that picks the rule. Each rule fixes the event being watched and the window length in parallel clock cycles. Ordered-set decoders upstream deliver one-cycle detect strobes.

An electrical-idle ordered set seen while inference is enabled raises the flag on the next clock. The flag drops only when the watched event recurs, the selector changes, inference is disabled, or reset is applied. An idle-exit indication is never used to clear the flag unless the active rule itself watches for it. The two short windows assume a 16-bit path that carries two 10-UI symbols per cycle: 1280 UI is 64 cycles and 2000 UI is 100 cycles. The long window of 128 µs is a parameter given in clock cycles.

Top module: `eidle_infer`

## Requirements
- R1: While the selector's top bit is 0 (values 3'b000 to 3'b011), the idle output is low one clock later and stays low, whatever the strobes do, including the idle ordered-set strobe.
- R2: Selector 3'b100 watches flow-control-update and skip strobes. Either one restarts the window. The output rises at the LONG_WIN-th rising edge after the last edge at which such a strobe or a selector change was sampled.
- R3: Selector 3'b101 watches the training-set strobe with a window of CFG_WIN cycles (default 64), timed as in R2.
- R4: Selector 3'b110 watches the idle-exit strobe with a window of SPD_WIN cycles (default 100). The training-set, flow-control and skip strobes do not restart this window.
- R5: Selector 3'b111 watches the idle-exit strobe with a window of LONG_WIN cycles.
- R6: With the selector's top bit at 1, an idle ordered-set strobe makes the output high one clock later. This takes priority over the watched event and over a selector change sampled on the same edge.
- R7: Under selectors 3'b100 and 3'b101, the idle-exit strobe has no effect on the output or on the window.
- R8: Once high, the output holds until the watched event is sampled (it is then low one clock later), the selector changes, or reset is applied.
- R9: A change of selector value clears the output and restarts the window from zero, so the new rule's full window must elapse before the output rises.
- R10: An active-low asynchronous reset drives the output low at once and treats the first selector value seen afterwards as a change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parallel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| state_sel | input | 3 | Link-training state selector that picks the rule |
| fc_upd_det | input | 1 | Flow-control update received this cycle |
| skp_det | input | 1 | Skip ordered set received this cycle |
| ts_det | input | 1 | TS1 or TS2 ordered set received this cycle |
| eidle_os_det | input | 1 | Electrical-idle ordered set received this cycle |
| idle_exit_det | input | 1 | Exit from electrical idle observed this cycle |
| idle_out | output | 1 | Inferred electrical idle for this receiver |

## Verification
A wrong window count shows at the port as a rise of the idle output one or more edges too early or too late. The bench therefore runs each window to exactly one edge short of expiry and then one edge further. A watch multiplexer that picks the wrong strobe for a rule shows within one cycle: a strobe clears the output when it should not, or fails to clear it when it should. A stale copy of the previous selector shows as an output that survives a selector change. These faults are caught at the first sampled edge after the change, or no later than one window afterwards.

// File: rtl/eidle_pkg.sv
package eidle_pkg;

  typedef enum logic [2:0] {
    RULE_OFF,
    RULE_LINK,
    RULE_CFG,
    RULE_SPDFAIL,
    RULE_LPBK
  } rule_e;

  function automatic rule_e rule_of(input logic [2:0] sel);
    rule_e r;
    case (sel)
      3'b100:  r = RULE_LINK;
      3'b101:  r = RULE_CFG;
      3'b110:  r = RULE_SPDFAIL;
      3'b111:  r = RULE_LPBK;
      default: r = RULE_OFF;
    endcase
    return r;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/eidle_sel_decode.sv
module eidle_sel_decode
  import eidle_pkg::*;
#(
  parameter int LONG_WIN = 16000,
  parameter int CFG_WIN  = 64,
  parameter int SPD_WIN  = 100,
  parameter int CNT_W    = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       state_sel,
  input  logic             fc_upd_det,
  input  logic             skp_det,
  input  logic             ts_det,
  input  logic             idle_exit_det,
  output logic             enabled,
  output logic             sel_chg,
  output logic             hit,
  output logic [CNT_W-1:0] last
);

  localparam logic [CNT_W-1:0] LAST_LONG = CNT_W'(LONG_WIN - 1);
  localparam logic [CNT_W-1:0] LAST_CFG  = CNT_W'(CFG_WIN - 1);
  localparam logic [CNT_W-1:0] LAST_SPD  = CNT_W'(SPD_WIN - 1);

  logic [2:0] sel_q;
  rule_e      rule;

  function automatic logic [CNT_W-1:0] last_of(input rule_e r);
    case (r)
      RULE_CFG:     return LAST_CFG;
      RULE_SPDFAIL: return LAST_SPD;
      RULE_LINK,
      RULE_LPBK:    return LAST_LONG;
      default:      return '0;
    endcase
  endfunction

  function automatic logic watched(input rule_e r, input logic fc, input logic skp,
                                   input logic ts, input logic ext);
    case (r)
      RULE_LINK:    return fc | skp;
      RULE_CFG:     return ts;
      RULE_SPDFAIL,
      RULE_LPBK:    return ext;
      default:      return 1'b0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 3'b000;
    else        sel_q <= state_sel;
  end

  always_comb begin
    rule    = rule_of(state_sel);
    enabled = (rule != RULE_OFF);
    sel_chg = (state_sel != sel_q);
    hit     = watched(rule, fc_upd_det, skp_det, ts_det, idle_exit_det);
    last    = last_of(rule);
  end

endmodule

// File: rtl/eidle_window_timer.sv
module eidle_window_timer #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [CNT_W-1:0] last,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);

  logic at_last;

  assign at_last = (cnt == last);
  assign expire  = !clear && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (clear)    cnt <= '0;
    else if (!at_last) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/eidle_idle_latch.sv
module eidle_idle_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic enabled,
  input  logic eos,
  input  logic sel_chg,
  input  logic hit,
  input  logic expire,
  output logic idle_q
);

  logic idle_d;

  always_comb begin
    if (!enabled)            idle_d = 1'b0;
    else if (eos)            idle_d = 1'b1;
    else if (sel_chg || hit) idle_d = 1'b0;
    else if (expire)         idle_d = 1'b1;
    else                     idle_d = idle_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_q <= 1'b0;
    else        idle_q <= idle_d;
  end

endmodule

// File: rtl/eidle_infer.sv
module eidle_infer
  import eidle_pkg::*;
#(
  parameter int LONG_WIN = 16000,
  parameter int CFG_WIN  = 64,
  parameter int SPD_WIN  = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] state_sel,
  input  logic       fc_upd_det,
  input  logic       skp_det,
  input  logic       ts_det,
  input  logic       eidle_os_det,
  input  logic       idle_exit_det,
  output logic       idle_out
);

  localparam int MAX_WIN = max3(LONG_WIN, CFG_WIN, SPD_WIN);
  localparam int CNT_W   = (MAX_WIN < 2) ? 1 : $clog2(MAX_WIN);

  logic             enabled;
  logic             sel_chg;
  logic             hit;
  logic             clear;
  logic             expire;
  logic [CNT_W-1:0] last;
  logic [CNT_W-1:0] cnt;

  eidle_sel_decode #(
    .LONG_WIN (LONG_WIN),
    .CFG_WIN  (CFG_WIN),
    .SPD_WIN  (SPD_WIN),
    .CNT_W    (CNT_W)
  ) u_dec (
    .clk           (clk),
    .rst_n         (rst_n),
    .state_sel     (state_sel),
    .fc_upd_det    (fc_upd_det),
    .skp_det       (skp_det),
    .ts_det        (ts_det),
    .idle_exit_det (idle_exit_det),
    .enabled       (enabled),
    .sel_chg       (sel_chg),
    .hit           (hit),
    .last          (last)
  );

  assign clear = !enabled || sel_chg || hit;

  eidle_window_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (clear),
    .last   (last),
    .cnt    (cnt),
    .expire (expire)
  );

  eidle_idle_latch u_lat (
    .clk     (clk),
    .rst_n   (rst_n),
    .enabled (enabled),
    .eos     (eidle_os_det),
    .sel_chg (sel_chg),
    .hit     (hit),
    .expire  (expire),
    .idle_q  (idle_out)
  );

endmodule

// File: rtl/eidle_infer_chk.sv
module eidle_infer_chk #(
  parameter int CNT_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       state_sel,
  input logic             fc_upd_det,
  input logic             skp_det,
  input logic             eidle_os_det,
  input logic             idle_exit_det,
  input logic             idle_out,
  input logic             sel_chg,
  input logic             hit,
  input logic             expire,
  input logic [CNT_W-1:0] cnt
);

  // R1: a disabled selector forces the flag low
  a_r1_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    !state_sel[2] |=> !idle_out);

  // R6: idle ordered set raises the flag directly
  a_r6_eos_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (state_sel[2] && eidle_os_det) |=> idle_out);

  // R8: the watched event drops the flag
  a_r8_hit_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (state_sel[2] && hit && !eidle_os_det) |=> !idle_out);

  // R8: the flag rises only from an idle ordered set or a full window
  a_r8_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_out) |-> ($past(eidle_os_det) || $past(expire)));

  // R9: a selector change restarts the window
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    sel_chg |=> (cnt == '0));

  // R7: idle-exit strobe cannot drop the flag under the link rule
  a_r7_exit_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state_sel == 3'b100 && !sel_chg && idle_out && idle_exit_det &&
     !fc_upd_det && !skp_det) |=> idle_out);

endmodule

bind eidle_infer eidle_infer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .state_sel     (state_sel),
  .fc_upd_det    (fc_upd_det),
  .skp_det       (skp_det),
  .eidle_os_det  (eidle_os_det),
  .idle_exit_det (idle_exit_det),
  .idle_out      (idle_out),
  .sel_chg       (sel_chg),
  .hit           (hit),
  .expire        (expire),
  .cnt           (cnt)
);

// File: tb/tb_eidle_infer.sv
module tb_eidle_infer;

  localparam int LW = 200;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] state_sel;
  logic       fc_upd_det, skp_det, ts_det, eidle_os_det, idle_exit_det;
  logic       idle_out;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  eidle_infer #(.LONG_WIN(LW), .CFG_WIN(64), .SPD_WIN(100)) dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .state_sel     (state_sel),
    .fc_upd_det    (fc_upd_det),
    .skp_det       (skp_det),
    .ts_det        (ts_det),
    .eidle_os_det  (eidle_os_det),
    .idle_exit_det (idle_exit_det),
    .idle_out      (idle_out)
  );

  typedef struct packed {
    logic [2:0]  sel;
    logic        fc;
    logic        skp;
    logic        ts;
    logic        eos;
    logic        ext;
    logic [15:0] reps;
    logic        exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 37;
  // fields: sel, fc, skp, ts, eos, ext, edges held, expected flag, requirement
  localparam vec_t VECS [NV] = '{
    '{3'b000,1'b0,1'b0,1'b0,1'b0,1'b0,16'd300,1'b0,8'd1},  // R1 never times out
    '{3'b000,1'b0,1'b0,1'b0,1'b1,1'b0,16'd1,  1'b0,8'd1},  // R1 idle OS ignored
    '{3'b101,1'b0,1'b0,1'b0,1'b0,1'b0,16'd64, 1'b0,8'd3},  // R3 one short
    '{3'b101,1'b0,1'b0,1'b0,1'b0,1'b0,16'd1,  1'b1,8'd3},  // R3 expiry
    '{3'b101,1'b0,1'b0,1'b1,1'b0,1'b0,16'd1,  1'b0,8'd8},  // R8 TS clears
    '{3'b101,1'b0,1'b0,1'b0,1'b0,1'b0,16'd63, 1'b0,8'd3},  // R3 one short
    '{3'b101,1'b0,1'b0,1'b0,1'b0,1'b0,16'd1,  1'b1,8'd3},  // R3 expiry after event
    '{3'b101,1'b0,1'b0,1'b0,1'b0,1'b1,16'd5,  1'b1,8'd7},  // R7 exit ignored
    '{3'b110,1'b0,1'b0,1'b0,1'b0,1'b0,16'd100,1'b0,8'd4},  // R4 one short
    '{3'b110,1'b0,1'b0,1'b0,1'b0,1'b0,16'd1,  1'b1,8'd4},  // R4 expiry
    '{3'b110,1'b0,1'b0,1'b0,1'b0,1'b1,16'd1,  1'b0,8'd4},  // R4 exit clears
    '{3'b110,1'b0,1'b0,1'b0,1'b0,1'b0,16'd40, 1'b0,8'd4},
    '{3'b110,1'b1,1'b1,1'b1,1'b0,1'b0,16'd1,  1'b0,8'd4},  // R4 other strobes
    '{3'b110,1'b0,1'b0,1'b0,1'b0,1'b0,16'd58, 1'b0,8'd4},
    '{3'b110,1'b0,1'b0,1'b0,1'b0,1'b0,16'd1,  1'b1,8'd4},  // R4 no restart
    '{3'b100,1'b0,1'b0,1'b0,1'b0,1'b0,16'd200,1'b0,8'd2},  // R2 one short
    '{3'b100,1'b0,1'b0,1'b0,1'b0,1'b0,16'd1,  1'b1,8'd2},  // R2 expiry
    '{3'b100,1'b0,1'b1,1'b0,1'b0,1'b0,16'd1,  1'b0,8'd2},  // R2 skip clears
    '{3'b100,1'b0,1'b0,1'b0,1'b0,1'b0,16'd100,1'b0,8'd2},
    '{3'b100,1'b1,1'b0,1'b0,1'b0,1'b0,16'd1,  1'b0,8'd2},  // R2 FC restarts
    '{3'b100,1'b0,1'b0,1'b0,1'b0,1'b0,16'd199,1'b0,8'd2},
    '{3'b100,1'b0,1'b0,1'b0,1'b0,1'b0,16'd1,  1'b1,8'd2},  // R2 expiry after FC
    '{3'b100,1'b0,1'b0,1'b0,1'b0,1'b1,16'd3,  1'b1,8'd7},  // R7 exit ignored
    '{3'b100,1'b0,1'b0,1'b0,1'b1,1'b0,16'd1,  1'b1,8'd6},  // R6 stays high
    '{3'b111,1'b0,1'b0,1'b0,1'b0,1'b0,16'd200,1'b0,8'd5},  // R5 one short
    '{3'b111,1'b0,1'b0,1'b0,1'b0,1'b0,16'd1,  1'b1,8'd5},  // R5 expiry
    '{3'b111,1'b0,1'b0,1'b0,1'b0,1'b1,16'd1,  1'b0,8'd5},  // R5 exit clears
    '{3'b111,1'b0,1'b0,1'b0,1'b1,1'b0,16'd1,  1'b1,8'd6},  // R6 immediate
    '{3'b111,1'b0,1'b0,1'b0,1'b0,1'b0,16'd5,  1'b1,8'd8},  // R8 holds
    '{3'b011,1'b0,1'b0,1'b0,1'b0,1'b0,16'd1,  1'b0,8'd1},  // R1 forced low
    '{3'b101,1'b0,1'b0,1'b0,1'b1,1'b0,16'd1,  1'b1,8'd6},  // R6 beats change
    '{3'b101,1'b0,1'b0,1'b1,1'b1,1'b0,16'd1,  1'b1,8'd6},  // R6 beats event
    '{3'b101,1'b0,1'b0,1'b1,1'b0,1'b0,16'd1,  1'b0,8'd8},  // R8 event clears
    '{3'b101,1'b0,1'b0,1'b0,1'b0,1'b0,16'd40, 1'b0,8'd9},
    '{3'b110,1'b0,1'b0,1'b0,1'b0,1'b0,16'd60, 1'b0,8'd9},  // R9 change
    '{3'b101,1'b0,1'b0,1'b0,1'b0,1'b0,16'd64, 1'b0,8'd9},  // R9 full new window
    '{3'b101,1'b0,1'b0,1'b0,1'b0,1'b0,16'd1,  1'b1,8'd9}   // R9 expiry
  };

  task automatic check(input logic exp, input string req);
    n_chk++;
    if (idle_out !== exp) begin
      n_bad++;
      $display("FAIL %s: idle_out=%b expected=%b at %0t", req, idle_out, exp, $time);
    end
  endtask

  task automatic drive(input logic [2:0] s, input logic f, input logic k,
                       input logic t, input logic e, input logic x);
    state_sel = s; fc_upd_det = f; skp_det = k;
    ts_det = t; eidle_os_det = e; idle_exit_det = x;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: idle_out=%b expected=finished", idle_out);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    check(1'b0, "R10 reset state");
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].sel, VECS[i].fc, VECS[i].skp, VECS[i].ts,
            VECS[i].eos, VECS[i].ext);
      repeat (int'(VECS[i].reps)) @(negedge clk);
      check(VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i));
    end

    // R10: reset while the flag is high
    rst_n = 1'b0;
    #1;
    check(1'b0, "R10 async reset");
    @(negedge clk);
    check(1'b0, "R10 held in reset");
    rst_n = 1'b1;
    // R10: selector after reset is a change, full window applies
    repeat (64) @(negedge clk);
    check(1'b0, "R10 window after reset");
    @(negedge clk);
    check(1'b1, "R10 expiry after reset");

    // R1: a disabled value clears within one edge, then stays low
    drive(3'b010, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    check(1'b0, "R1 disable clears");
    repeat (70) @(negedge clk);
    check(1'b0, "R1 stays low");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule